// File: doc/BRIEF.md
# Serial-Input Membership Function Evaluator

This block evaluates a quantized membership function on a crisp input that arrives one bit per clock cycle, most significant bit first. The function is held as a lookup table parameter with one scaled membership level per input code. A larger output width gives a finer scaling of the levels. The block is a Mealy machine whose hidden state is a node of a binary tree of input prefixes. The root is node 1, and each accepted bit moves the tree from node `s` to node `2*s + bit`.

Each output digit is released as soon as the prefix seen so far fixes it. For digit `k` this happens after a fixed number of consumed input bits, its online delay. The delay is a parameter, and by default it is derived from the table as the shortest prefix length that fixes that digit. Approximating the table can therefore shorten the delay of a digit. A per-digit valid flag tells the downstream min/max logic when each digit can be used. That logic can then start its own most-significant-first comparison before the whole input word has arrived.

A control machine sequences each word. After reset it waits in `ST_IDLE`. A start strobe takes it from any state to `ST_SHIFT` (transition "restart"). In `ST_SHIFT`, each qualified bit advances the tree (transition "consume"). The N-th consumed bit moves it to `ST_DONE` (transition "finish"). In `ST_DONE` it holds until the next start (transition "restart").

Top module: `mfz_membership_fsm`

## Requirements
- R1: After reset, `mu_o` and `mu_valid_o` are all zero, and no bit is consumed until a start strobe is seen.
- R2: In the cycle after `start_i`, `mu_valid_o[k]` is 1 exactly for the digits whose online delay is 0. Each such digit shows its constant value, and every other digit is cleared to 0.
- R3: After N consumed bits with no intervening start, all digits are valid and `mu_o` equals the table level of the received word. The table entry for code `c` sits at bits `[c*W+W-1 : c*W]`, and the first bit received is the word's most significant bit.
- R4: `mu_valid_o[k]` rises in the cycle after the consumed bit that brings the count of consumed bits to the delay of digit `k`, and never earlier.
- R5: Once a digit is valid, its valid flag and value hold until the next start strobe.
- R6: A cycle with `bit_valid_i` low changes nothing. Bits offered before the first start, or after N bits have been consumed, are ignored.
- R7: When `start_i` and `bit_valid_i` are high in the same cycle, the start wins and that bit is not consumed.
- R8: The default delay of each digit is the shortest prefix length after which that digit's value no longer depends on the remaining bits. A digit released at that point already carries its final value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new word; returns the prefix tree to its root |
| bit_i | input | 1 | Serial input bit, most significant first |
| bit_valid_i | input | 1 | Qualifies `bit_i` in this cycle |
| mu_o | output | W_OUT | Membership level digits; digit k is meaningful when its valid flag is set |
| mu_valid_o | output | W_OUT | Per-digit valid flags |

## Verification
The assertions assume that the table parameter and the delay parameter agree. They also assume that a word may be cut short only by a new start, and that inputs are stable around the rising edge. The stimulus keeps to this by driving the inputs only on falling edges and by using the default, table-derived delays in one instance. A second instance carries a stepped table that gives zero and one-bit delays. Random words with random idle gaps, restarts in the middle of a word, a start that coincides with a bit, and bits offered in the idle and done states together cover every transition of the control machine.

// File: rtl/mfz_pkg.sv
package mfz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } mfz_state_e;

    localparam int unsigned TAB_MAX_BITS = 4096;
    localparam int unsigned DLY_FIELD    = 8;
    localparam int unsigned DLY_MAX_BITS = 128;

    // digit k of every leaf below each depth-d prefix is identical
    function automatic logic digit_fixed_at(input logic [TAB_MAX_BITS-1:0] tab,
                                            input int n, input int w,
                                            input int k, input int d);
        for (int i = 0; i < (1 << n); i++) begin
            int base;
            base = (i >> (n - d)) << (n - d);
            if (tab[base*w + k] != tab[i*w + k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [DLY_MAX_BITS-1:0] min_delays(input logic [TAB_MAX_BITS-1:0] tab,
                                                            input int n, input int w);
        logic [DLY_MAX_BITS-1:0] r;
        r = '0;
        for (int k = 0; k < w; k++) begin
            for (int d = n; d >= 0; d--) begin
                if (digit_fixed_at(tab, n, w, k, d)) r[k*DLY_FIELD +: DLY_FIELD] = 8'(d);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mfz_seq_ctrl.sv
module mfz_seq_ctrl
    import mfz_pkg::*;
#(
    parameter int unsigned N_IN = 4,
    localparam int unsigned CW  = $clog2(N_IN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          bit_valid_i,
    output logic          restart_o,
    output logic          accept_o,
    output logic [CW-1:0] cnt_o
);

    mfz_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        restart_o = 1'b0;
        accept_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    restart_o = 1'b1;
                    cnt_d     = '0;
                    state_d   = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (start_i) begin
                    restart_o = 1'b1;
                    cnt_d     = '0;
                end else if (bit_valid_i) begin
                    accept_o = 1'b1;
                    cnt_d    = cnt_q + 1'b1;
                    if (cnt_q == CW'(N_IN - 1)) state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (start_i) begin
                    restart_o = 1'b1;
                    cnt_d     = '0;
                    state_d   = ST_SHIFT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/mfz_prefix_tree.sv
module mfz_prefix_tree #(
    parameter int unsigned N_IN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          accept_i,
    input  logic          bit_i,
    output logic [N_IN:0] next_node_o
);

    logic [N_IN:0] node_q;

    // child of node s on bit b is 2*s + b
    assign next_node_o = {node_q[N_IN-1:0], bit_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         node_q <= (N_IN+1)'(1);
        else if (restart_i) node_q <= (N_IN+1)'(1);
        else if (accept_i)  node_q <= next_node_o;
    end

endmodule

// File: rtl/mfz_digit_slot.sv
module mfz_digit_slot #(
    parameter int unsigned N_IN = 4,
    parameter int unsigned DLY  = 4,
    localparam int unsigned CW    = $clog2(N_IN + 1),
    localparam int unsigned NLEAF = 1 << N_IN,
    localparam int unsigned SH    = N_IN - DLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             accept_i,
    input  logic [CW-1:0]    cnt_i,
    input  logic [N_IN:0]    next_node_i,
    input  logic [NLEAF-1:0] col_i,
    output logic             dig_o,
    output logic             dig_valid_o
);

    logic [N_IN-1:0] leaf_idx;
    logic            hit;

    // first leaf under the prefix reached by this transition
    assign leaf_idx = N_IN'(next_node_i << SH);
    assign hit      = accept_i && (DLY != 0) &&
                      (cnt_i == CW'((DLY == 0) ? 0 : DLY - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dig_o       <= 1'b0;
            dig_valid_o <= 1'b0;
        end else if (restart_i) begin
            dig_valid_o <= (DLY == 0);
            dig_o       <= (DLY == 0) ? col_i[0] : 1'b0;
        end else if (hit) begin
            dig_valid_o <= 1'b1;
            dig_o       <= col_i[leaf_idx];
        end
    end

endmodule

// File: rtl/mfz_membership_fsm.sv
module mfz_membership_fsm #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned W_OUT = 4,
    parameter logic [(1<<N_IN)*W_OUT-1:0] TABLE = 64'h047B_FFFF_D962_0000,
    parameter logic [mfz_pkg::DLY_MAX_BITS-1:0] DELAYS =
        mfz_pkg::min_delays(mfz_pkg::TAB_MAX_BITS'(TABLE), N_IN, W_OUT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bit_i,
    input  logic             bit_valid_i,
    output logic [W_OUT-1:0] mu_o,
    output logic [W_OUT-1:0] mu_valid_o
);

    localparam int unsigned CW    = $clog2(N_IN + 1);
    localparam int unsigned NLEAF = 1 << N_IN;

    logic          restart;
    logic          accept;
    logic [CW-1:0] cnt;
    logic [N_IN:0] next_node;

    mfz_seq_ctrl #(.N_IN(N_IN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .bit_valid_i(bit_valid_i),
        .restart_o  (restart),
        .accept_o   (accept),
        .cnt_o      (cnt)
    );

    mfz_prefix_tree #(.N_IN(N_IN)) u_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .accept_i   (accept),
        .bit_i      (bit_i),
        .next_node_o(next_node)
    );

    for (genvar k = 0; k < W_OUT; k++) begin : g_digit
        localparam int unsigned DK = int'(DELAYS[k*mfz_pkg::DLY_FIELD +: mfz_pkg::DLY_FIELD]);
        logic [NLEAF-1:0] col;
        for (genvar i = 0; i < NLEAF; i++) begin : g_col
            assign col[i] = TABLE[i*W_OUT + k];
        end
        mfz_digit_slot #(.N_IN(N_IN), .DLY(DK)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .restart_i  (restart),
            .accept_i   (accept),
            .cnt_i      (cnt),
            .next_node_i(next_node),
            .col_i      (col),
            .dig_o      (mu_o[k]),
            .dig_valid_o(mu_valid_o[k])
        );
    end

endmodule

// File: rtl/mfz_checker.sv
module mfz_checker #(
    parameter int unsigned N_IN  = 4,
    parameter int unsigned W_OUT = 4,
    parameter logic [(1<<N_IN)*W_OUT-1:0] TABLE = '0,
    parameter logic [mfz_pkg::DLY_MAX_BITS-1:0] DELAYS = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bit_i,
    input logic             bit_valid_i,
    input logic [W_OUT-1:0] mu_o,
    input logic [W_OUT-1:0] mu_valid_o
);

    localparam int unsigned CW = $clog2(N_IN + 1);

    logic            ck_on;
    logic [CW-1:0]   ck_cnt;
    logic [N_IN-1:0] ck_word;
    logic [W_OUT-1:0] zero_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_on   <= 1'b0;
            ck_cnt  <= '0;
            ck_word <= '0;
        end else if (start_i) begin
            ck_on   <= 1'b1;
            ck_cnt  <= '0;
            ck_word <= '0;
        end else if (ck_on && bit_valid_i && ck_cnt < CW'(N_IN)) begin
            ck_cnt  <= ck_cnt + 1'b1;
            ck_word <= N_IN'({ck_word, bit_i});
        end
    end

    for (genvar k = 0; k < W_OUT; k++) begin : g_chk
        localparam int unsigned DK = int'(DELAYS[k*mfz_pkg::DLY_FIELD +: mfz_pkg::DLY_FIELD]);
        assign zero_mask[k] = (DK == 0);

        p_rise_at_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mu_valid_o[k]) |-> (ck_cnt == CW'(DK)));
    end

    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mu_valid_o == zero_mask));

    p_word_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_on && ck_cnt == CW'(N_IN)) |->
            ((mu_valid_o == '1) && (mu_o == TABLE[ck_word*W_OUT +: W_OUT])));

    p_valid_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (($past(mu_valid_o) & ~mu_valid_o) == '0));

    p_value_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (((mu_o ^ $past(mu_o)) & $past(mu_valid_o)) == '0));

    p_idle_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !bit_valid_i) |=> ($stable(mu_valid_o) && $stable(mu_o)));

    p_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ck_on |-> (mu_valid_o == '0));

endmodule

bind mfz_membership_fsm mfz_checker #(
    .N_IN  (N_IN),
    .W_OUT (W_OUT),
    .TABLE (TABLE),
    .DELAYS(DELAYS)
) u_mfz_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .bit_i      (bit_i),
    .bit_valid_i(bit_valid_i),
    .mu_o       (mu_o),
    .mu_valid_o (mu_valid_o)
);

// File: tb/test_mfz_membership_fsm.sv
`timescale 1ns/1ps
module test_mfz_membership_fsm;

    localparam int N = 4;
    localparam int W = 4;
    localparam logic [63:0] TAB_A = 64'h047B_FFFF_D962_0000;
    localparam logic [63:0] TAB_B = 64'h9999_9999_1111_1111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st = 1'b0, bi = 1'b0, bv = 1'b0;
    logic [W-1:0] mu_a, mv_a, mu_b, mv_b;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    int m_on = 0;
    int m_cnt = 0;
    logic [N-1:0] cur_word = '0;
    int dly_a[W];
    int dly_b[W];

    always #4 clk = ~clk;

    mfz_membership_fsm #(.N_IN(N), .W_OUT(W), .TABLE(TAB_A)) i_mfz_membership_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(st), .bit_i(bi), .bit_valid_i(bv),
        .mu_o(mu_a), .mu_valid_o(mv_a));

    mfz_membership_fsm #(.N_IN(N), .W_OUT(W), .TABLE(TAB_B)) i_mfz_membership_fsm_step (
        .clk(clk), .rst_n(rst_n), .start_i(st), .bit_i(bi), .bit_valid_i(bv),
        .mu_o(mu_b), .mu_valid_o(mv_b));

    // shortest prefix length for which every completion agrees on digit k
    function automatic int bench_delay(logic [63:0] tab, int k);
        for (int d = 0; d <= N; d++) begin
            bit ok = 1;
            for (int p = 0; p < (1 << d); p++) begin
                logic r;
                r = tab[(p << (N - d)) * W + k];
                for (int s = 0; s < (1 << (N - d)); s++)
                    if (tab[((p << (N - d)) | s) * W + k] != r) ok = 0;
            end
            if (ok) return d;
        end
        return N;
    endfunction

    function automatic logic [W-1:0] exp_valid(int dl[W]);
        logic [W-1:0] v;
        for (int k = 0; k < W; k++) v[k] = (m_on != 0) && (m_cnt >= dl[k]);
        return v;
    endfunction

    task automatic compare(string tag, string who, logic [W-1:0] av, logic [W-1:0] am,
                           logic [W-1:0] ev, logic [W-1:0] em);
        n_checks++;
        if (av !== ev || am !== em) begin
            n_fail++;
            $display("FAIL %s %s: valid=%b mu=%b expected valid=%b mu=%b", tag, who, av, am, ev, em);
        end
    endtask

    task automatic check(string tag);
        logic [W-1:0] ev;
        ev = exp_valid(dly_a);
        compare(tag, "tableA", mv_a, mu_a, ev, TAB_A[cur_word*W +: W] & ev);
        ev = exp_valid(dly_b);
        compare(tag, "tableB", mv_b, mu_b, ev, TAB_B[cur_word*W +: W] & ev);
    endtask

    // called at a falling edge; the model mirrors the coming rising edge
    task automatic drive(logic s, logic v, logic b, string tag);
        st = s; bv = v; bi = b;
        if (s) begin
            m_on = 1; m_cnt = 0;
        end else if (m_on != 0 && v && m_cnt < N) begin
            m_cnt++;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic send_word(logic [N-1:0] w, int gap_pct, string tag);
        cur_word = w;
        drive(1'b1, 1'b0, 1'b0, tag);
        for (int i = N - 1; i >= 0; i--) begin
            while (($urandom % 100) < gap_pct) drive(1'b0, 1'b0, 1'($urandom), tag);
            drive(1'b0, 1'b1, w[i], tag);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int k = 0; k < W; k++) begin
            dly_a[k] = bench_delay(TAB_A, k);
            dly_b[k] = bench_delay(TAB_B, k);
        end
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");
        // R6: bits before any start are ignored
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, "R1 R6 no start");

        // R2 R4: directed word with a gap between bits
        send_word(4'b0110, 40, "R2 R4 directed");
        // R6: bits after the word is complete are ignored
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'($urandom), "R6 after done");

        // R7: start and bit together, bit not consumed
        cur_word = 4'b1011;
        drive(1'b1, 1'b1, 1'b0, "R7 start with bit");
        for (int i = N - 1; i >= 0; i--) drive(1'b0, 1'b1, cur_word[i], "R7 follow");

        // R2: restart in the middle of a word
        cur_word = 4'b1100;
        drive(1'b1, 1'b0, 1'b0, "R2 first");
        drive(1'b0, 1'b1, 1'b1, "R2 partial");
        drive(1'b0, 1'b1, 1'b1, "R2 partial");
        send_word(4'b0011, 0, "R2 restart mid word");

        // R3 R8: every code, no gaps
        for (int c = 0; c < (1 << N); c++) send_word(N'(c), 0, "R3 R8 all codes");

        // R5 R6: random words with random gaps
        for (int j = 0; j < 300; j++) begin
            send_word(N'($urandom), 30, "R5 R6 random");
            if (($urandom % 4) == 0) drive(1'b0, 1'b1, 1'($urandom), "R6 extra bit");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule